// File: doc/BRIEF.md
# Decoupled Integer Multiply/Divide Unit

This block is an iterative multiply and divide engine that sits beside a 32-bit integer pipeline. The pipeline hands it two operands and an operation code, and then keeps issuing unrelated instructions. The unit grinds through the operation over a fixed number of cycles. A multiply leaves the 64-bit product split across a pair of dedicated result registers. A divide leaves the quotient in the low register and the remainder in the high register. Software can also load either result register directly.

The command and write channels carry only a valid strobe. They are accepted in any cycle and never apply back-pressure. The read channel is valid/ready. `rd_ready` is low while an operation is in flight. A read presented during that time is held off and `rd_stall` is raised for the pipeline. The read completes in the first cycle in which `rd_valid` and `rd_ready` are both high, and `rd_data` then carries the selected register in that same cycle. Issuing a command never stalls. Only a later read of the result registers waits for the result.

Latency is fixed: 12 cycles for a multiply and 35 for a divide, counted from the clock edge that accepts the command. A new command or a direct register write that arrives mid-operation cancels the operation in flight.

Top module: `muldiv_unit`

## Requirements
- R1: With `cmd_op`=0 (multiply), the 64-bit product of `cmd_a` and `cmd_b` is written with bits 31:0 to LO and bits 63:32 to HI. `cmd_signed`=1 treats both operands as two's complement and `cmd_signed`=0 treats them as unsigned.
- R2: With `cmd_op`=1 (divide) and a nonzero divisor, LO receives the quotient and HI the remainder. In signed mode the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R3: LO and HI take the result at the 12th clock edge after the accepting edge for a multiply, or at the 35th for a divide. `done` is high for exactly the one cycle that follows that edge.
- R4: `busy` rises in the cycle after a command is accepted and stays high until the result edge. A command is always accepted and causes no stall.
- R5: `rd_ready` equals the inverse of `busy`, and `rd_stall` is high exactly when `rd_valid` is high while busy. When a read completes, `rd_data` shows LO for `rd_sel`=0 and HI for `rd_sel`=1.
- R6: LO and HI hold their values in every cycle that has neither a result write nor a direct write.
- R7: `wr_valid` loads `wr_data` into LO (`wr_sel`=0) or HI (`wr_sel`=1), and the value is visible from the next cycle. If an operation is in flight, including on its final cycle, the operation is cancelled: no result is written and `busy` falls in the next cycle.
- R8: A command accepted while busy discards the operation in flight, even on its final cycle, and the latency restarts from the new command. If `wr_valid` arrives in the same cycle, the write is applied and the new operation still runs.
- R9: A divide by zero takes the normal 35 cycles and sets LO to all ones and HI to the dividend, in both signed and unsigned mode.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R11: After reset, LO and HI are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Start an operation (always accepted) |
| cmd_op | input | 1 | 0 = multiply, 1 = divide |
| cmd_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| cmd_a | input | 32 | Multiplicand or dividend |
| cmd_b | input | 32 | Multiplier or divisor |
| wr_valid | input | 1 | Direct write to a result register |
| wr_sel | input | 1 | Write target: 0 = LO, 1 = HI |
| wr_data | input | 32 | Value to write |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 1 | Read source: 0 = LO, 1 = HI |
| rd_ready | output | 1 | Read can complete this cycle |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Read is waiting on an operation in flight |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Result written at the previous edge |

## Verification
The sharpest collision is an operation reaching its result edge in the same cycle that a direct write or a new command arrives. The result must then be dropped in favour of the write or the restart. The bench provokes this by counting idle cycles exactly from issue and placing `wr_valid` or `cmd_valid` on the final cycle. It also places both in one cycle. A behavioural model holds the remaining-cycle count and the pending result, and every cycle it compares `busy`, `done`, the read handshake and the data read back.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int MUL_LAT   = 12,
  parameter int DIV_LAT   = 35,
  parameter int MUL_STEPS = 11,
  parameter int DIV_STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  op_e  cmd_op,
  input  logic wr_fire,
  output logic busy,
  output logic done,
  output logic step,
  output logic commit
);
  localparam int LAT_MAX = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int CW      = $clog2(LAT_MAX + 1);
  localparam logic [CW-1:0] MUL_END  = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] DIV_END  = CW'(DIV_LAT - 1);
  localparam logic [CW-1:0] MUL_STOP = CW'(MUL_STEPS);
  localparam logic [CW-1:0] DIV_STOP = CW'(DIV_STEPS);

  op_e           op_q;
  logic [CW-1:0] elapsed;
  logic          last;

  always_comb begin
    last   = busy && (elapsed == ((op_q == OP_DIV) ? DIV_END : MUL_END));
    step   = busy && (elapsed < ((op_q == OP_DIV) ? DIV_STOP : MUL_STOP));
    commit = last && !cmd_fire && !wr_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      elapsed <= '0;
      op_q    <= OP_MUL;
    end else begin
      done <= commit;
      if (cmd_fire) begin
        busy    <= 1'b1;
        elapsed <= '0;
        op_q    <= cmd_op;
      end else if (wr_fire) begin
        busy <= 1'b0;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (busy && elapsed == '0)); // R4
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !cmd_fire) |=> !busy); // R7
  AST_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (elapsed < CW'(LAT_MAX))); // R3
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MUL_BITS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  op_e             op,
  input  logic            sgn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            step,
  output logic [XLEN-1:0] res_lo,
  output logic [XLEN-1:0] res_hi
);
  localparam int PW        = 2 * XLEN;
  localparam int MUL_STEPS = (XLEN + MUL_BITS - 1) / MUL_BITS;
  localparam int MW        = MUL_STEPS * MUL_BITS;

  op_e             op_q;
  logic            neg_main, neg_rem, dz;
  logic [XLEN-1:0] dividend_q, divisor;
  logic [PW-1:0]   mul_acc, mul_cand;
  logic [MW-1:0]   mul_plier;
  logic [XLEN-1:0] div_rem, div_quo;

  // operand magnitudes
  logic [XLEN-1:0] a_mag, b_mag;
  logic            a_neg, b_neg;
  always_comb begin
    a_neg = sgn && opa[XLEN-1];
    b_neg = sgn && opb[XLEN-1];
    a_mag = a_neg ? (~opa + 1'b1) : opa;
    b_mag = b_neg ? (~opb + 1'b1) : opb;
  end

  // multiply: one partial-product term per retired multiplier bit
  logic [PW-1:0] pp_term [MUL_BITS];
  logic [PW-1:0] pp_sum;
  for (genvar g = 0; g < MUL_BITS; g++) begin : g_pp
    assign pp_term[g] = mul_plier[g] ? (mul_cand << g) : '0;
  end
  always_comb begin
    pp_sum = '0;
    for (int i = 0; i < MUL_BITS; i++) pp_sum = pp_sum + pp_term[i];
  end

  // divide: one restoring step
  logic [XLEN:0]   shifted;
  logic [XLEN+1:0] trial;
  logic            take;
  logic [XLEN-1:0] rem_next;
  always_comb begin
    shifted  = {div_rem, div_quo[XLEN-1]};
    trial    = {1'b0, shifted} - {2'b00, divisor};
    take     = !trial[XLEN+1];
    rem_next = take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_MUL;
      neg_main   <= 1'b0;
      neg_rem    <= 1'b0;
      dz         <= 1'b0;
      dividend_q <= '0;
      divisor    <= '0;
      mul_acc    <= '0;
      mul_cand   <= '0;
      mul_plier  <= '0;
      div_rem    <= '0;
      div_quo    <= '0;
    end else if (load) begin
      op_q       <= op;
      dz         <= (opb == '0);
      neg_main   <= (a_neg ^ b_neg) && (opb != '0);
      neg_rem    <= a_neg;
      dividend_q <= opa;
      divisor    <= b_mag;
      mul_acc    <= '0;
      mul_cand   <= PW'(b_mag);
      mul_plier  <= MW'(a_mag);
      div_rem    <= '0;
      div_quo    <= a_mag;
    end else if (step) begin
      if (op_q == OP_DIV) begin
        div_rem <= rem_next;
        div_quo <= {div_quo[XLEN-2:0], take};
      end else begin
        mul_acc   <= mul_acc + pp_sum;
        mul_cand  <= mul_cand << MUL_BITS;
        mul_plier <= mul_plier >> MUL_BITS;
      end
    end
  end

  // sign fix-up on the finished magnitudes
  logic [PW-1:0] prod;
  always_comb begin
    prod = neg_main ? (~mul_acc + 1'b1) : mul_acc;
    if (op_q == OP_DIV) begin
      res_lo = dz ? '1 : (neg_main ? (~div_quo + 1'b1) : div_quo);
      res_hi = dz ? dividend_q : (neg_rem ? (~div_rem + 1'b1) : div_rem);
    end else begin
      res_lo = prod[XLEN-1:0];
      res_hi = prod[PW-1:XLEN];
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_DIV && divisor != '0) |-> (div_rem < divisor)); // R2
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [XLEN-1:0] res_lo,
  input  logic [XLEN-1:0] res_hi,
  input  logic            wr_fire,
  input  logic            wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            rd_sel,
  output logic [XLEN-1:0] rd_data
);
  logic [XLEN-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (commit) begin
      lo_q <= res_lo;
      hi_q <= res_hi;
    end else if (wr_fire) begin
      if (wr_sel) hi_q <= wr_data;
      else        lo_q <= wr_data;
    end
  end

  assign rd_data = rd_sel ? hi_q : lo_q;

  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !wr_fire) |=> ($stable(lo_q) && $stable(hi_q))); // R6
  AST_COMMIT_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && wr_fire)); // R7
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MUL_BITS = 3,
  parameter int MUL_LAT  = 12,
  parameter int DIV_LAT  = 35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_op,
  input  logic            cmd_signed,
  input  logic [XLEN-1:0] cmd_a,
  input  logic [XLEN-1:0] cmd_b,
  input  logic            wr_valid,
  input  logic            wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            rd_valid,
  input  logic            rd_sel,
  output logic            rd_ready,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_stall,
  output logic            busy,
  output logic            done
);
  localparam int MUL_STEPS = (XLEN + MUL_BITS - 1) / MUL_BITS;
  localparam int DIV_STEPS = XLEN;

  op_e             op_in;
  logic            step, commit;
  logic [XLEN-1:0] res_lo, res_hi;

  assign op_in = cmd_op ? OP_DIV : OP_MUL;

  muldiv_ctrl #(
    .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
    .MUL_STEPS(MUL_STEPS), .DIV_STEPS(DIV_STEPS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_valid), .cmd_op(op_in),
    .wr_fire(wr_valid), .busy(busy), .done(done), .step(step), .commit(commit)
  );

  muldiv_dp #(.XLEN(XLEN), .MUL_BITS(MUL_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid), .op(op_in), .sgn(cmd_signed),
    .opa(cmd_a), .opb(cmd_b), .step(step), .res_lo(res_lo), .res_hi(res_hi)
  );

  muldiv_hilo #(.XLEN(XLEN)) hilo_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .res_lo(res_lo), .res_hi(res_hi),
    .wr_fire(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  assign rd_ready = !busy;
  assign rd_stall = rd_valid && busy;

  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_ready && !rd_stall)); // R5
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_MUL = 12;
  localparam int LAT_DIV = 35;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n;
  logic        cmd_valid, cmd_op, cmd_signed;
  logic [31:0] cmd_a, cmd_b;
  logic        wr_valid, wr_sel;
  logic [31:0] wr_data;
  logic        rd_valid, rd_sel;
  logic        rd_ready, rd_stall, busy, done;
  logic [31:0] rd_data;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_signed(cmd_signed), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_stall(rd_stall), .busy(busy), .done(done)
  );

  // reference model state
  bit          m_busy, m_done;
  int          m_cnt;
  logic [31:0] m_lo, m_hi, m_plo, m_phi;

  int    checks = 0, failures = 0;
  string cur_req = "R11";
  bit    finished = 0;

  function automatic void ref_op(input logic op, input logic sg, input logic [31:0] a,
                                 input logic [31:0] b, output logic [31:0] lo,
                                 output logic [31:0] hi);
    longint sa, sb, sq, sr;
    longint unsigned ua, ub, p;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    if (!op) begin
      p  = sg ? longint'(sa * sb) : ua * ub;
      lo = p[31:0];
      hi = p[63:32];
    end else if (b == 32'b0) begin
      lo = '1;
      hi = a;
    end else if (sg) begin
      sq = sa / sb;
      sr = sa % sb;
      lo = sq[31:0];
      hi = sr[31:0];
    end else begin
      p  = ua / ub;
      lo = p[31:0];
      p  = ua % ub;
      hi = p[31:0];
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: drive, compare against model, advance model
  task automatic cyc(input logic cv, input logic op, input logic sg, input logic [31:0] a,
                     input logic [31:0] b, input logic wv, input logic ws,
                     input logic [31:0] wd, input logic rv, input logic rs);
    bit          n_busy, n_done;
    int          n_cnt;
    logic [31:0] n_lo, n_hi, n_plo, n_phi, sel;
    cmd_valid = cv; cmd_op = op; cmd_signed = sg; cmd_a = a; cmd_b = b;
    wr_valid = wv; wr_sel = ws; wr_data = wd; rd_valid = rv; rd_sel = rs;
    #1;
    check(busy === m_busy, "R4", "busy", 32'(busy), 32'(m_busy));
    check(done === m_done, "R3", "done", 32'(done), 32'(m_done));
    check(rd_ready === !m_busy, "R5", "rd_ready", 32'(rd_ready), 32'(!m_busy));
    check(rd_stall === (rv && m_busy), "R5", "rd_stall", 32'(rd_stall), 32'(rv && m_busy));
    if (rv && !m_busy) begin
      sel = rs ? m_hi : m_lo;
      check(rd_data === sel, cur_req, "rd_data", rd_data, sel);
    end
    n_busy = m_busy; n_cnt = m_cnt; n_done = 1'b0;
    n_lo = m_lo; n_hi = m_hi; n_plo = m_plo; n_phi = m_phi;
    if (wv) begin
      if (ws) n_hi = wd;
      else    n_lo = wd;
    end
    if (cv) begin
      n_busy = 1'b1;
      n_cnt  = op ? LAT_DIV : LAT_MUL;
      ref_op(op, sg, a, b, n_plo, n_phi);
    end else if (wv) begin
      n_busy = 1'b0;
    end else if (m_busy) begin
      n_cnt--;
      if (n_cnt == 0) begin
        n_busy = 1'b0;
        n_done = 1'b1;
        n_lo   = m_plo;
        n_hi   = m_phi;
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_busy = n_busy; m_cnt = n_cnt; m_done = n_done;
    m_lo = n_lo; m_hi = n_hi; m_plo = n_plo; m_phi = n_phi;
  endtask

  task automatic idle(input int n, input logic rv);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, '0, 0, 0, '0, rv, i[0]);
  endtask

  task automatic issue(input logic op, input logic sg, input logic [31:0] a,
                       input logic [31:0] b);
    cyc(1, op, sg, a, b, 0, 0, '0, 0, 0);
  endtask

  task automatic write_reg(input logic ws, input logic [31:0] wd);
    cyc(0, 0, 0, '0, '0, 1, ws, wd, 0, 0);
  endtask

  // issue, poll with reads until finished, then read both halves
  task automatic run_op(input logic op, input logic sg, input logic [31:0] a,
                        input logic [31:0] b, input string req);
    cur_req = req;
    issue(op, sg, a, b);
    for (int i = 0; i < 40 && m_busy; i++) cyc(0, 0, 0, '0, '0, 0, 0, '0, 1, i[0]);
    idle(2, 1);
  endtask

  initial begin
    int unsigned r;
    logic [31:0] ra, rb;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_op = 0; cmd_signed = 0; cmd_a = '0; cmd_b = '0;
    wr_valid = 0; wr_sel = 0; wr_data = '0; rd_valid = 0; rd_sel = 0;
    m_busy = 0; m_done = 0; m_cnt = 0; m_lo = '0; m_hi = '0; m_plo = '0; m_phi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R11"; idle(3, 1);
    cur_req = "R7";
    write_reg(0, 32'h1234_5678);
    write_reg(1, 32'h9ABC_DEF0);
    cur_req = "R6"; idle(4, 1);

    run_op(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    run_op(0, 0, 32'd123456, 32'd654321, "R1");
    run_op(0, 1, 32'hFFFF_FFFD, 32'd7, "R1");
    run_op(0, 1, 32'h8000_0000, 32'h8000_0000, "R1");
    run_op(1, 0, 32'd100, 32'd7, "R2");
    run_op(1, 0, 32'hFFFF_FFFF, 32'd3, "R2");
    run_op(1, 1, 32'hFFFF_FFF9, 32'd2, "R2");
    run_op(1, 1, 32'd7, 32'hFFFF_FFFE, "R2");
    run_op(1, 1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R2");
    run_op(1, 0, 32'hDEAD_BEEF, 32'd0, "R9");
    run_op(1, 1, 32'hFFFF_FF00, 32'd0, "R9");
    run_op(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R10");

    // restart while busy: divide replaced by multiply
    cur_req = "R8";
    issue(1, 0, 32'd1000, 32'd3);
    idle(10, 1);
    run_op(0, 0, 32'd77, 32'd11, "R8");

    // write while busy cancels the multiply
    cur_req = "R7";
    issue(0, 0, 32'd5, 32'd6);
    idle(4, 1);
    write_reg(1, 32'hCAFE_0001);
    idle(15, 1);

    // write on the final cycle of a multiply (collision)
    issue(0, 1, 32'hFFFF_FFF0, 32'd9);
    idle(LAT_MUL - 1, 0);
    write_reg(0, 32'h0BAD_F00D);
    idle(4, 1);

    // new command on the final cycle of a divide (collision)
    cur_req = "R8";
    issue(1, 0, 32'd999, 32'd10);
    idle(LAT_DIV - 1, 0);
    run_op(0, 0, 32'd3, 32'd4, "R8");

    // command and write in one cycle while busy
    issue(1, 1, 32'd50, 32'd5);
    idle(3, 1);
    cyc(1, 0, 1, 32'hFFFF_FFFF, 32'd2, 1, 1, 32'h5555_AAAA, 0, 0);
    idle(2, 1);
    idle(LAT_MUL, 1);

    // random traffic with corner operands
    cur_req = "R3";
    for (int i = 0; i < 1500; i++) begin
      r  = $urandom;
      ra = (r[3:2] == 0) ? 32'h8000_0000 : (r[3:2] == 1) ? 32'hFFFF_FFFF : 32'($urandom);
      rb = (r[5:4] == 0) ? 32'd0 : (r[5:4] == 1) ? 32'hFFFF_FFFF : 32'($urandom);
      cyc(r[12:8] == 0, r[13], r[14], ra, rb, r[22:18] == 0, r[23], 32'($urandom),
          r[24], r[25]);
    end
    idle(LAT_DIV + 2, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule